// File: doc/BRIEF.md
# Protected Dual-Region Parity RAM Controller

This block sits in front of two contiguous on-chip RAM regions of equal size. It serves a single-port request/response bus with no wait states. Each request carries an address, byte strobes, write data and a one-bit requester identity: 0 is the host and 1 is the privileged requester. The response comes back in the next cycle. The whole span of both regions can be reached through a primary window and an alias window, and both windows address the same storage.

Every byte lane keeps an even-parity bit. The bit is produced on write and checked on read. A read whose accessed lanes fail the parity check still returns its data, and the controller flags it and records the address. A bitmap with one bit per page blocks writes. A page-bounded secure window refuses host accesses outright. A separate configuration port programs the bitmap and the window bounds.

The defaults are 32 pages of 64 bytes per region, which keeps elaboration small. A deployment sets `PAGE_BYTES` to 1024 and `PRI_BASE` to 0x2003_0000. This gives two 32 KB regions with the second at 0x2003_8000, the alias at 0x1000_0000 / 0x1000_8000, and 64 pages of 1 KB.

Top module: `prot_sram_ctrl`

## Requirements
- R1: Region 0 begins at `PRI_BASE` and region 1 follows it directly at `PRI_BASE`+32·`PAGE_BYTES`. The same storage is reached from `ALI_BASE` at the same offset. Accesses are word wide, and address bits [1:0] are ignored.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req` high, and low otherwise.
- R3: An address outside both windows gives `rsp_code` 1 (decode error) and `rdata` 0, and it changes no memory.
- R4: A write changes only the byte lanes whose `be` bit is set. Lane n is `wdata[8n+7:8n]`.
- R5: Each lane stores even parity. It is inverted when the matching `inj_par` bit is set during the write. A successful read with a mismatch in any lane enabled by `be` still returns the data with `rsp_code` 0, and it raises `rsp_perr`. Mismatches in lanes not enabled by `be` are ignored.
- R6: `fault_addr` resets to 0. It takes the full request address of each read that raises `rsp_perr`, and it changes in the same cycle as that response.
- R7: Page p is the byte offset from the window base divided by `PAGE_BYTES`, running 0..63 across both regions. While protect bit p is set, a write to page p from either requester is dropped with `rsp_code` 3. Reads of page p are unaffected.
- R8: The secure window covers pages start..end inclusive and is empty when start > end. A host access inside it gives `rsp_code` 2 and `rdata` 0, and a host write there is dropped. A privileged requester gets normal service inside the window.
- R9: When more than one check applies, the order is decode error, then secure refusal, then write protection.
- R10: A configuration write with `cfg_sel` 0 loads protect bits for pages 31..0 from `cfg_wdata[31:0]`. `cfg_sel` 1 loads pages 63..32. `cfg_sel` 2 loads the window, with start from `cfg_wdata[5:0]` and end from `cfg_wdata[21:16]`. After reset no page is protected and the window is empty (start 63, end 0).
- R11: `rdata` is 0 in every write response and in every error response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request valid |
| we | input | 1 | 1 = write, 0 = read |
| id | input | 1 | Requester: 0 host, 1 privileged |
| addr | input | 32 | Byte address |
| be | input | 4 | Byte-lane strobes |
| wdata | input | 32 | Write data |
| inj_par | input | 4 | Per-lane parity inversion on write (error injection) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | 32 | Configuration data |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 2 | 0 ok, 1 decode, 2 secure, 3 protected |
| rsp_perr | output | 1 | Parity error on this read response |
| rdata | output | 32 | Read data |
| fault_addr | output | 32 | Address of the last parity-failing read |

## Verification
The properties assume that `rst_n` is deasserted synchronously and that `req` is 0 while reset is held. They also assume that a request and a configuration write that touches the same page never occur in the same cycle, so that each response depends only on the configuration already in place. The stimulus changes inputs only on falling clock edges. It issues configuration writes in cycles without a request. It reads only words it has written before, so stored parity is never uninitialised when a read is checked against it.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [1:0] {
    RSP_OK   = 2'd0,
    RSP_DEC  = 2'd1,
    RSP_SEC  = 2'd2,
    RSP_PROT = 2'd3
  } rsp_code_e;

  // even parity bit for one byte lane
  function automatic logic lane_par(input logic [7:0] b);
    return ^b;
  endfunction

  // inclusive page span test; lo > hi gives an empty span
  function automatic logic in_span(input logic [15:0] p,
                                   input logic [15:0] lo,
                                   input logic [15:0] hi);
    return (p >= lo) && (p <= hi);
  endfunction

endpackage

// File: rtl/psram_decode.sv
module psram_decode #(
  parameter logic [31:0] PRI_BASE = 32'h2003_0000,
  parameter logic [31:0] ALI_BASE = 32'h1000_0000,
  parameter int SPAN  = 4096,
  parameter int IW    = 10,
  parameter int PGW   = 6,
  parameter int PG_SH = 6
) (
  input  logic [31:0]    addr,
  output logic           hit,
  output logic [IW-1:0]  idx,
  output logic [PGW-1:0] page
);
  logic [1:0]  win_hit;
  logic [31:0] win_off [2];

  for (genvar w = 0; w < 2; w++) begin : g_win
    localparam logic [31:0] B = (w == 0) ? PRI_BASE : ALI_BASE;
    assign win_off[w] = addr - B;
    assign win_hit[w] = (addr >= B) && (win_off[w] < 32'(SPAN));
  end

  logic [31:0] off;
  assign off  = win_hit[0] ? win_off[0] : win_off[1];
  assign hit  = |win_hit;
  assign idx  = IW'(off >> 2);
  assign page = PGW'(off >> PG_SH);
endmodule

// File: rtl/psram_guard.sv
module psram_guard
  import psram_pkg::*;
#(
  parameter int PAGES = 64,
  parameter int PGW   = 6
) (
  input  logic             req,
  input  logic             we,
  input  logic             id,
  input  logic             hit,
  input  logic [PGW-1:0]   page,
  input  logic [PAGES-1:0] prot_map,
  input  logic [PGW-1:0]   sec_lo,
  input  logic [PGW-1:0]   sec_hi,
  output rsp_code_e        code,
  output logic             mem_we
);
  logic sec_blk, prot_blk;

  assign sec_blk  = hit && !id && in_span(16'(page), 16'(sec_lo), 16'(sec_hi));
  assign prot_blk = hit && we && prot_map[page];

  always_comb begin
    if (!hit)          code = RSP_DEC;
    else if (sec_blk)  code = RSP_SEC;
    else if (prot_blk) code = RSP_PROT;
    else               code = RSP_OK;
  end

  assign mem_we = req && we && (code == RSP_OK);
endmodule

// File: rtl/psram_cfg.sv
module psram_cfg #(
  parameter int PAGES = 64,
  parameter int PGW   = 6,
  parameter int NPW   = 2,
  parameter int CSW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CSW-1:0]   cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [PAGES-1:0] prot_map,
  output logic [PGW-1:0]   sec_lo,
  output logic [PGW-1:0]   sec_hi
);
  logic [NPW*32-1:0] prot_words;

  for (genvar w = 0; w < NPW; w++) begin : g_pw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prot_words[w*32 +: 32] <= '0;
      else if (cfg_we && cfg_sel == CSW'(w))
        prot_words[w*32 +: 32] <= cfg_wdata;
    end
  end
  assign prot_map = prot_words[PAGES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_lo <= '1;
      sec_hi <= '0;
    end else if (cfg_we && cfg_sel == CSW'(NPW)) begin
      sec_lo <= cfg_wdata[PGW-1:0];
      sec_hi <= cfg_wdata[16 +: PGW];
    end
  end

  // R10: configuration only moves on a configuration write
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(prot_map) && $stable(sec_lo) && $stable(sec_hi));
endmodule

// File: rtl/psram_store.sv
module psram_store
  import psram_pkg::*;
#(
  parameter int WORDS = 1024,
  parameter int IW    = 10,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               we,
  input  logic [IW-1:0]      idx,
  input  logic [LANES-1:0]   be,
  input  logic [8*LANES-1:0] wdata,
  input  logic [LANES-1:0]   inj,
  output logic [8*LANES-1:0] rdata,
  output logic [LANES-1:0]   mism
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] dmem [WORDS];
    logic       pmem [WORDS];

    always_ff @(posedge clk) begin
      if (we && be[l]) begin
        dmem[idx] <= wdata[8*l +: 8];
        pmem[idx] <= lane_par(wdata[8*l +: 8]) ^ inj[l];
      end
    end

    assign rdata[8*l +: 8] = dmem[idx];
    assign mism[l]         = lane_par(dmem[idx]) ^ pmem[idx];
  end
endmodule

// File: rtl/prot_sram_ctrl.sv
module prot_sram_ctrl
  import psram_pkg::*;
#(
  parameter logic [31:0] PRI_BASE     = 32'h2003_0000,
  parameter logic [31:0] ALI_BASE     = 32'h1000_0000,
  parameter int          REGION_PAGES = 32,
  parameter int          PAGE_BYTES   = 64,
  localparam int PAGES = 2 * REGION_PAGES,
  localparam int NPW   = (PAGES + 31) / 32,
  localparam int CSW   = $clog2(NPW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic           we,
  input  logic           id,
  input  logic [31:0]    addr,
  input  logic [3:0]     be,
  input  logic [31:0]    wdata,
  input  logic [3:0]     inj_par,
  input  logic           cfg_we,
  input  logic [CSW-1:0] cfg_sel,
  input  logic [31:0]    cfg_wdata,
  output logic           rsp_valid,
  output logic [1:0]     rsp_code,
  output logic           rsp_perr,
  output logic [31:0]    rdata,
  output logic [31:0]    fault_addr
);
  localparam int SPAN  = PAGES * PAGE_BYTES;
  localparam int OFF_W = $clog2(SPAN);
  localparam int IW    = OFF_W - 2;
  localparam int WORDS = SPAN / 4;
  localparam int PGW   = $clog2(PAGES);
  localparam int PG_SH = $clog2(PAGE_BYTES);

  // named internal events
  logic             dec_hit;
  logic [IW-1:0]    word_idx;
  logic [PGW-1:0]   page;
  logic [PAGES-1:0] prot_map;
  logic [PGW-1:0]   sec_lo, sec_hi;
  rsp_code_e        code_d;
  logic             mem_we;
  logic [31:0]      st_rdata;
  logic [3:0]       st_mism;
  logic             rd_ok, perr_d;

  psram_decode #(.PRI_BASE(PRI_BASE), .ALI_BASE(ALI_BASE), .SPAN(SPAN),
                 .IW(IW), .PGW(PGW), .PG_SH(PG_SH)) u_dec (
    .addr(addr), .hit(dec_hit), .idx(word_idx), .page(page));

  psram_cfg #(.PAGES(PAGES), .PGW(PGW), .NPW(NPW), .CSW(CSW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .prot_map(prot_map), .sec_lo(sec_lo), .sec_hi(sec_hi));

  psram_guard #(.PAGES(PAGES), .PGW(PGW)) u_grd (
    .req(req), .we(we), .id(id), .hit(dec_hit), .page(page),
    .prot_map(prot_map), .sec_lo(sec_lo), .sec_hi(sec_hi),
    .code(code_d), .mem_we(mem_we));

  psram_store #(.WORDS(WORDS), .IW(IW), .LANES(4)) u_mem (
    .clk(clk), .we(mem_we), .idx(word_idx), .be(be), .wdata(wdata),
    .inj(inj_par), .rdata(st_rdata), .mism(st_mism));

  assign rd_ok  = req && !we && (code_d == RSP_OK);
  assign perr_d = rd_ok && |(st_mism & be);

  rsp_code_e code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      code_q     <= RSP_OK;
      rsp_perr   <= 1'b0;
      rdata      <= '0;
      fault_addr <= '0;
    end else begin
      rsp_valid <= req;
      code_q    <= req ? code_d : RSP_OK;
      rsp_perr  <= perr_d;
      rdata     <= rd_ok ? st_rdata : '0;
      if (perr_d) fault_addr <= addr;
    end
  end

  assign rsp_code = code_q;

  // R2: one response per request, in the following cycle
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);
  p_idle_no_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid);

  // R3: decoder miss never writes storage and reports a decode error
  p_dec_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> dec_hit);
  p_dec_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req && !dec_hit |=> code_q == RSP_DEC && rdata == '0);

  // R5: parity flag only on a successful read response
  p_perr_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perr |-> rsp_valid && code_q == RSP_OK && $past(!we));

  // R6: captured fault address is the failing request address
  p_fault_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perr |-> fault_addr == $past(addr));

  // R7: a protected page never reaches storage
  p_prot_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req && we && dec_hit && prot_map[page] |-> !mem_we);

  // R8: host inside the secure window is refused with no data
  p_sec_deny_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req && dec_hit && !id && in_span(16'(page), 16'(sec_lo), 16'(sec_hi))
    |=> code_q == RSP_SEC && rdata == '0);

  // R11: writes never return data
  p_wr_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req && we |=> rdata == '0);
endmodule

// File: tb/sim_prot_sram_ctrl.sv
module sim_prot_sram_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic req, we, id, cfg_we;
  logic [31:0] addr, wdata, cfg_wdata;
  logic [3:0] be, inj_par;
  logic [1:0] cfg_sel;
  logic rsp_valid, rsp_perr;
  logic [1:0] rsp_code;
  logic [31:0] rdata, fault_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  prot_sram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .id(id), .addr(addr),
    .be(be), .wdata(wdata), .inj_par(inj_par), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_perr(rsp_perr), .rdata(rdata),
    .fault_addr(fault_addr));

  typedef struct packed {
    logic        w;
    logic        who;
    logic [31:0] a;
    logic [3:0]  b;
    logic [31:0] d;
    logic [1:0]  code;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 32'h2003_0000, 4'hF, 32'h1122_3344, 2'd0, 32'h0},          // R1
    '{1'b0, 1'b0, 32'h1000_0000, 4'hF, 32'h0,         2'd0, 32'h1122_3344},  // R1 alias
    '{1'b1, 1'b0, 32'h1000_0806, 4'hF, 32'hAABB_CCDD, 2'd0, 32'h0},          // R1 region 1, low bits
    '{1'b0, 1'b0, 32'h2003_0804, 4'hF, 32'h0,         2'd0, 32'hAABB_CCDD},
    '{1'b1, 1'b0, 32'h2003_0008, 4'hF, 32'h0,         2'd0, 32'h0},          // R4
    '{1'b1, 1'b0, 32'h2003_0008, 4'h5, 32'hFFFF_FFFF, 2'd0, 32'h0},
    '{1'b0, 1'b0, 32'h2003_0008, 4'hF, 32'h0,         2'd0, 32'h00FF_00FF},
    '{1'b0, 1'b0, 32'h2003_1000, 4'hF, 32'h0,         2'd1, 32'h0},          // R3
    '{1'b1, 1'b0, 32'h0FFF_FFFC, 4'hF, 32'h5555_5555, 2'd1, 32'h0},
    '{1'b0, 1'b1, 32'h1000_1000, 4'hF, 32'h0,         2'd1, 32'h0},
    '{1'b0, 1'b0, 32'h2002_FFFC, 4'hF, 32'h0,         2'd1, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample the response one full cycle later
  task automatic bus(input logic w, input logic who, input logic [31:0] a,
                     input logic [3:0] b, input logic [31:0] d, input logic [3:0] inj);
    req = 1'b1; we = w; id = who; addr = a; be = b; wdata = d; inj_par = inj;
    @(negedge clk);
    req = 1'b0; we = 1'b0; inj_par = 4'h0;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_exp(input string tag, input logic who, input logic [31:0] a,
                        input logic [1:0] code, input logic [31:0] d);
    bus(1'b0, who, a, 4'hF, 32'h0, 4'h0);
    chk({tag, " code"}, 32'(rsp_code), 32'(code));
    chk({tag, " data"}, rdata, d);
  endtask

  task automatic wr_exp(input string tag, input logic who, input logic [31:0] a,
                        input logic [31:0] d, input logic [1:0] code);
    bus(1'b1, who, a, 4'hF, d, 4'h0);
    chk({tag, " code"}, 32'(rsp_code), 32'(code));
    chk({tag, " data"}, rdata, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; we = 1'b0; id = 1'b0; addr = '0; be = '0;
    wdata = '0; inj_par = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // reset state (R2, R6)
    chk("R2 reset valid", 32'(rsp_valid), 32'h0);
    chk("R6 reset fault_addr", fault_addr, 32'h0);
    chk("R11 reset rdata", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R1, R3, R4, R11
    for (int i = 0; i < NV; i++) begin
      bus(VT[i].w, VT[i].who, VT[i].a, VT[i].b, VT[i].d, 4'h0);
      chk($sformatf("R1/R3/R4 vec%0d valid", i), 32'(rsp_valid), 32'h1);
      chk($sformatf("R1/R3/R4 vec%0d code", i), 32'(rsp_code), 32'(VT[i].code));
      chk($sformatf("R11 vec%0d rdata", i), rdata, VT[i].rd);
      chk($sformatf("R5 vec%0d perr", i), 32'(rsp_perr), 32'h0);
    end

    // R2: idle cycle gives no response
    @(negedge clk);
    chk("R2 idle valid", 32'(rsp_valid), 32'h0);

    // R7 write protection on pages 1 and 32
    wr_exp("R7 prep p1", 1'b0, 32'h2003_0040, 32'h5A5A_5A5A, 2'd0);
    wr_exp("R7 prep p32", 1'b0, 32'h2003_0800, 32'h0000_0077, 2'd0);
    cfg(2'd0, 32'h0000_0002);
    cfg(2'd1, 32'h0000_0001);
    wr_exp("R7 block p1", 1'b0, 32'h2003_0040, 32'h0BAD_0BAD, 2'd3);
    wr_exp("R7 block p1 alias", 1'b1, 32'h1000_0040, 32'h0BAD_0BAD, 2'd3);
    rd_exp("R7 read p1", 1'b0, 32'h2003_0040, 2'd0, 32'h5A5A_5A5A);
    wr_exp("R7 block p32", 1'b0, 32'h2003_0800, 32'h0BAD_0BAD, 2'd3);
    rd_exp("R7 read p32", 1'b0, 32'h2003_0800, 2'd0, 32'h0000_0077);
    wr_exp("R7 open p34", 1'b0, 32'h2003_0880, 32'h0000_0088, 2'd0);

    // R8 secure window pages 4..5
    cfg(2'd2, 32'h0005_0004);
    wr_exp("R8 priv write", 1'b1, 32'h2003_0100, 32'hCAFE_0001, 2'd0);
    rd_exp("R8 host read", 1'b0, 32'h2003_0100, 2'd2, 32'h0);
    wr_exp("R8 host write", 1'b0, 32'h2003_0100, 32'hDEAD_DEAD, 2'd2);
    rd_exp("R8 priv read", 1'b1, 32'h2003_0100, 2'd0, 32'hCAFE_0001);
    rd_exp("R8 host last word", 1'b0, 32'h2003_017C, 2'd2, 32'h0);
    wr_exp("R8 host page6", 1'b0, 32'h2003_0180, 32'h0000_0006, 2'd0);
    wr_exp("R8 host page3", 1'b0, 32'h2003_00FC, 32'h0000_0003, 2'd0);
    rd_exp("R8 host page6 read", 1'b0, 32'h1000_0180, 2'd0, 32'h0000_0006);

    // R9 priority: page 4 also protected
    cfg(2'd0, 32'h0000_0012);
    wr_exp("R9 host sec over prot", 1'b0, 32'h2003_0100, 32'h1, 2'd2);
    wr_exp("R9 priv prot", 1'b1, 32'h2003_0100, 32'h1, 2'd3);
    rd_exp("R9 priv read", 1'b1, 32'h2003_0100, 2'd0, 32'hCAFE_0001);
    wr_exp("R9 decode first", 1'b0, 32'h2003_1100, 32'h1, 2'd1);

    // R10 empty window when start > end
    cfg(2'd2, 32'h0009_000A);
    rd_exp("R10 empty window", 1'b0, 32'h2003_0100, 2'd0, 32'hCAFE_0001);

    // R5/R6 parity injection on lane 1
    bus(1'b1, 1'b0, 32'h2003_0200, 4'hF, 32'h1234_5678, 4'b0010);
    chk("R5 inj write perr", 32'(rsp_perr), 32'h0);
    chk("R6 no capture on write", fault_addr, 32'h0);
    bus(1'b0, 1'b0, 32'h2003_0200, 4'hF, 32'h0, 4'h0);
    chk("R5 perr set", 32'(rsp_perr), 32'h1);
    chk("R5 data kept", rdata, 32'h1234_5678);
    chk("R5 code ok", 32'(rsp_code), 32'h0);
    chk("R6 fault addr", fault_addr, 32'h2003_0200);
    bus(1'b0, 1'b0, 32'h1000_0200, 4'b1101, 32'h0, 4'h0);
    chk("R5 lane masked", 32'(rsp_perr), 32'h0);
    chk("R6 holds", fault_addr, 32'h2003_0200);
    bus(1'b0, 1'b0, 32'h1000_0202, 4'hF, 32'h0, 4'h0);
    chk("R5 alias perr", 32'(rsp_perr), 32'h1);
    chk("R6 alias addr", fault_addr, 32'h1000_0202);
    bus(1'b1, 1'b0, 32'h2003_0200, 4'b0010, 32'h0000_9900, 4'h0);
    bus(1'b0, 1'b0, 32'h2003_0200, 4'hF, 32'h0, 4'h0);
    chk("R5 repaired", 32'(rsp_perr), 32'h0);
    chk("R4 lane1 only", rdata, 32'h1234_9978);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule